// File: doc/BRIEF.md
# Serial Flash Receive Byte FIFO

This block is the receive side of a serial flash controller. Bits arrive on one, two or four data lanes, one beat at a time. A deserialiser assembles them into bytes, and the bytes are stored in a 64-byte FIFO in the order they arrive. Software empties the FIFO through a 32-bit data port. Each read returns up to four of the oldest bytes, with the oldest byte in the low-order position. A partial final word returns only the bytes it holds.

A small register window exposes four things. A status word gives a byte-granular fill count, three fill thresholds, a non-empty flag and an empty flag. A flush command discards all buffered data. An interrupt word holds two flags: one is set when a byte is stored, the other when software reads the data port while the FIFO is empty. A single interrupt line is high while either flag is set.

Top module: `sfc_rx_fifo`

## Requirements
- R1: With lane mode 0 (single lane), eight beats form one byte: lane 0 carries the bits most significant first.
- R2: With lane mode 1, four beats form a byte, and each beat supplies two bits with lane 1 as the higher bit. With lane mode 2, two beats form a byte, and each beat supplies four bits with lane 3 as the highest. Mode 3 acts as mode 0.
- R3: A read of address 0 returns the status word. Bit 0 is set when the FIFO is not empty. Bits 1, 2 and 3 are set when at least 16, 32 and 64 bytes are held. Bits 10:4 hold the byte count and bit 11 is set when the FIFO is empty. All other bits are zero.
- R4: A read of address 1 when four or more bytes are held returns the four oldest bytes, the oldest in bits 7:0 and the next ones in 15:8, 23:16 and 31:24. The count drops by 4.
- R5: A read of address 1 when one to three bytes are held returns those bytes in the low-order positions with zeros above them. The count drops to zero.
- R6: A write to address 2 with bit 0 set empties the FIFO and discards any partly assembled byte. With bit 0 clear the write has no effect.
- R7: A read of address 1 when the FIFO is empty returns zero, leaves the count at zero and sets bit 0 (underrun) of the interrupt word.
- R8: Bit 2 (ready) of the interrupt word is set whenever a byte is stored. The interrupt word is read at address 3. Writing 1s to address 3 clears the matching bits, and a set in the same cycle wins. irq_o is high while either bit is set.
- R9: The FIFO holds 64 bytes. A byte that completes while 64 are held is dropped, and the held contents and the count are unchanged.
- R10: After reset the count is zero, the status word reads 0x800, the interrupt word reads zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_mode_i | input | 2 | Lanes per beat: 0 one, 1 two, 2 four |
| beat_i | input | 1 | Lane sample valid this cycle |
| lanes_i | input | 4 | Data lane values |
| reg_rd_i | input | 1 | Register read strobe (data port read pops) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 data, 2 flush, 3 interrupt |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt, high while a flag is set |

## Verification
A read pointer or fill count that goes wrong shows up at the very next data-port read. The read returns bytes out of order, stale bytes where zeros belong, or a word that the status count does not match. The status word shows a bad count in the same cycle, because it is built directly from the count. A deserialiser that loses bit alignment corrupts every later byte, so a flush followed by one clean byte is used to expose a leftover partial byte. Dropped or duplicated bytes at the full boundary show up when the whole FIFO is drained and compared byte for byte.

// File: rtl/sfc_rx_pkg.sv
package sfc_rx_pkg;
  localparam int LANE_N = 4;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_RSV = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_DATA   = 2'd1,
    ADDR_FLUSH  = 2'd2,
    ADDR_IRQ    = 2'd3
  } reg_addr_e;

  localparam int IRQ_UNDER_BIT = 0;
  localparam int IRQ_READY_BIT = 2;
endpackage

// File: rtl/sfc_rx_deser.sv
module sfc_rx_deser
  import sfc_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  lane_mode_e        mode_i,
  input  logic              beat_i,
  input  logic [LANE_N-1:0] lanes_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  bits_q;
  logic [CNT_W-1:0]  step;
  logic [CNT_W:0]    bits_sum;
  logic              done;

  always_comb begin
    unique case (mode_i)
      LANE_X2: begin
        step = CNT_W'(2);
        sh_d = {sh_q[BYTE_W-3:0], lanes_i[1:0]};
      end
      LANE_X4: begin
        step = CNT_W'(4);
        sh_d = {sh_q[BYTE_W-5:0], lanes_i[3:0]};
      end
      default: begin
        step = CNT_W'(1);
        sh_d = {sh_q[BYTE_W-2:0], lanes_i[0]};
      end
    endcase
  end

  assign bits_sum   = {1'b0, bits_q} + {1'b0, step};
  assign done       = beat_i && (bits_sum >= (CNT_W+1)'(BYTE_W));
  assign byte_o     = sh_d;
  assign byte_vld_o = done && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (flush_i) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (beat_i) begin
      sh_q   <= sh_d;
      bits_q <= done ? '0 : bits_sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sfc_rx_store.sv
module sfc_rx_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_B = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TAKE_W = $clog2(WORD_B + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  push_i,
  input  logic [7:0]            byte_i,
  input  logic                  pop_i,
  output logic [8*WORD_B-1:0]   word_o,
  output logic [CNT_W-1:0]      fill_o,
  output logic                  stored_o
);
  // DEPTH must be a power of two so the pointers wrap naturally
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] fill_q;
  logic [TAKE_W-1:0] take, pop_n;
  logic             accept;

  assign accept = push_i && !flush_i && (fill_q < CNT_W'(DEPTH));
  assign take   = (fill_q >= CNT_W'(WORD_B)) ? TAKE_W'(WORD_B) : fill_q[TAKE_W-1:0];
  assign pop_n  = (pop_i && !flush_i) ? take : '0;

  for (genvar k = 0; k < WORD_B; k++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr_q + PTR_W'(k);
    assign word_o[8*k +: 8] = (CNT_W'(k) < fill_q) ? mem_q[idx] : 8'h00;
  end

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_ptr_q] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n);
      fill_q   <= fill_q + CNT_W'(accept) - CNT_W'(pop_n);
    end
  end

  assign fill_o   = fill_q;
  assign stored_o = accept;
endmodule

// File: rtl/sfc_rx_regs.sv
module sfc_rx_regs
  import sfc_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  reg_addr_e         reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [CNT_W-1:0]  fill_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              stored_i,
  output logic              pop_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int TH_LO  = DEPTH / 4;
  localparam int TH_MID = DEPTH / 2;
  localparam int CNT_LSB = 4;

  logic [DATA_W-1:0] status_w, irq_w;
  logic under_q, ready_q, underrun, clr_wr;

  assign pop_o    = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign flush_o  = reg_wr_i && (reg_addr_i == ADDR_FLUSH) && reg_wdata_i[0];
  assign underrun = pop_o && (fill_i == '0);
  assign clr_wr   = reg_wr_i && (reg_addr_i == ADDR_IRQ);

  always_comb begin
    status_w = '0;
    status_w[0] = (fill_i != '0);
    status_w[1] = (fill_i >= CNT_W'(TH_LO));
    status_w[2] = (fill_i >= CNT_W'(TH_MID));
    status_w[3] = (fill_i >= CNT_W'(DEPTH));
    status_w[CNT_LSB +: CNT_W] = fill_i;
    status_w[CNT_LSB + CNT_W]  = (fill_i == '0);
  end

  always_comb begin
    irq_w = '0;
    irq_w[IRQ_UNDER_BIT] = under_q;
    irq_w[IRQ_READY_BIT] = ready_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STATUS: reg_rdata_o = status_w;
      ADDR_DATA:   reg_rdata_o = word_i;
      ADDR_IRQ:    reg_rdata_o = irq_w;
      default:     reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      under_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      under_q <= underrun | (under_q & ~(clr_wr & reg_wdata_i[IRQ_UNDER_BIT]));
      ready_q <= stored_i | (ready_q & ~(clr_wr & reg_wdata_i[IRQ_READY_BIT]));
    end
  end

  assign irq_o = under_q | ready_q;
endmodule

// File: rtl/sfc_rx_fifo.sv
module sfc_rx_fifo
  import sfc_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int WORD_B = DATA_W / 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        lane_mode_i,
  input  logic              beat_i,
  input  logic [3:0]        lanes_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [7:0]        rx_byte;
  logic              rx_vld, flush, pop, stored;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W-1:0] word;

  sfc_rx_deser #(.BYTE_W(8)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .mode_i     (lane_mode_e'(lane_mode_i)),
    .beat_i     (beat_i),
    .lanes_i    (lanes_i),
    .byte_o     (rx_byte),
    .byte_vld_o (rx_vld)
  );

  sfc_rx_store #(.DEPTH(DEPTH), .WORD_B(WORD_B)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .push_i   (rx_vld),
    .byte_i   (rx_byte),
    .pop_i    (pop),
    .word_o   (word),
    .fill_o   (fill),
    .stored_o (stored)
  );

  sfc_rx_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_e'(reg_addr_i)),
    .reg_wdata_i (reg_wdata_i),
    .fill_i      (fill),
    .word_i      (word),
    .stored_i    (stored),
    .pop_o       (pop),
    .flush_o     (flush),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/sfc_rx_fifo_chk.sv
module sfc_rx_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_rd_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [31:0]      reg_rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] fill_i,
  input logic             stored_i
);
  logic data_rd, flush_wr;
  assign data_rd  = reg_rd_i && (reg_addr_i == 2'd1);
  assign flush_wr = reg_wr_i && (reg_addr_i == 2'd2) && reg_wdata_i[0];

  assert_fill_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CNT_W'(DEPTH));

  assert_full_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == CNT_W'(DEPTH) && !data_rd && !flush_wr) |=> fill_i == CNT_W'(DEPTH));

  assert_underrun_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && fill_i == '0) |-> reg_rdata_o == 32'h0);

  assert_underrun_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && fill_i == '0 && !flush_wr) |=> irq_o);

  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> fill_i == '0);

  assert_word_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && fill_i >= CNT_W'(4) && !stored_i && !flush_wr)
      |=> fill_i == CNT_W'($past(fill_i) - CNT_W'(4)));

  assert_ready_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stored_i |=> irq_o);
endmodule

bind sfc_rx_fifo sfc_rx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .fill_i      (fill),
  .stored_i    (stored)
);

// File: tb/sfc_rx_fifo_bench.sv
`timescale 1ns/1ps
module sfc_rx_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  lane_mode_i = 2'd0;
  logic        beat_i = 1'b0;
  logic [3:0]  lanes_i = 4'd0;
  logic        reg_rd_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] mq[$];

  always #2.5 clk = ~clk;

  sfc_rx_fifo u_sfc_rx_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .lane_mode_i(lane_mode_i), .beat_i(beat_i),
    .lanes_i(lanes_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [1:0] m);
    int beats;
    beats = (m == 2'd1) ? 4 : (m == 2'd2) ? 2 : 8;
    lane_mode_i = m;
    for (int i = 0; i < beats; i++) begin
      beat_i = 1'b1;
      if (m == 2'd1)      lanes_i = {2'b00, b[7-2*i -: 2]};
      else if (m == 2'd2) lanes_i = b[7-4*i -: 4];
      else                lanes_i = {3'b000, b[7-i]};
      @(negedge clk);
    end
    beat_i = 1'b0;
    if (mq.size() < 64) mq.push_back(b);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a;
    reg_wdata_i = d;
    reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  function automatic logic [31:0] model_pop();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (mq.size() > 0) w[8*k +: 8] = mq.pop_front();
    return w;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    reg_read(2'd0, d); chk("R10 status", d, 32'h800);
    reg_read(2'd3, d); chk("R10 irq word", d, 32'h0);
    chk("R10 irq_o", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_single_lane();
    logic [31:0] d;
    send_byte(8'h3C, 2'd0); send_byte(8'h81, 2'd0);
    send_byte(8'h5A, 2'd0); send_byte(8'hF0, 2'd0);
    reg_read(2'd0, d); chk("R3 status count 4", d, 32'h41);
    reg_read(2'd3, d); chk("R8 ready flag", d, 32'h4);
    chk("R8 irq_o set", {31'b0, irq_o}, 32'h1);
    reg_write(2'd3, 32'h4);
    reg_read(2'd3, d); chk("R8 w1c clear", d, 32'h0);
    chk("R8 irq_o clear", {31'b0, irq_o}, 32'h0);
    reg_read(2'd1, d); chk("R1 R4 word order", d, model_pop());
    reg_read(2'd0, d); chk("R4 status empty", d, 32'h800);
  endtask

  task automatic t_multi_lane();
    logic [31:0] d;
    send_byte(8'h12, 2'd1); send_byte(8'h34, 2'd1); send_byte(8'h56, 2'd1);
    send_byte(8'h78, 2'd2); send_byte(8'h9A, 2'd3 - 2'd1);
    reg_read(2'd1, d); chk("R2 two/four lane word", d, model_pop());
    reg_read(2'd0, d); chk("R3 status count 1", d, 32'h11);
    reg_read(2'd1, d); chk("R5 partial word", d, 32'h0000009A);
    void'(model_pop());
    reg_read(2'd0, d); chk("R5 empty after partial", d, 32'h800);
    send_byte(8'hC3, 2'd3);
    reg_read(2'd1, d); chk("R2 reserved mode as one lane", d, model_pop());
    reg_write(2'd3, 32'h5);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) send_byte(8'(8'h40 + i), 2'd2);
    lane_mode_i = 2'd2; beat_i = 1'b1; lanes_i = 4'hF;
    @(negedge clk);
    beat_i = 1'b0;
    reg_write(2'd2, 32'hFFFF_FFFE);
    reg_read(2'd0, d); chk("R6 flush bit0 clear no effect", d, 32'h61);
    reg_write(2'd2, 32'h1);
    mq.delete();
    reg_read(2'd0, d); chk("R6 flush empties", d, 32'h800);
    send_byte(8'hA5, 2'd2);
    reg_read(2'd1, d); chk("R6 partial byte discarded", d, model_pop());
    reg_write(2'd3, 32'h5);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    reg_read(2'd1, d); chk("R7 empty read zero", d, 32'h0);
    reg_read(2'd3, d); chk("R7 underrun flag", d, 32'h1);
    chk("R7 irq_o", {31'b0, irq_o}, 32'h1);
    reg_read(2'd0, d); chk("R7 count stays zero", d, 32'h800);
    reg_write(2'd3, 32'h1);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    for (int i = 0; i < 15; i++) send_byte(8'(i * 7 + 3), 2'd2);
    reg_read(2'd0, d); chk("R3 status 15", d, 32'hF1);
    send_byte(8'(15 * 7 + 3), 2'd2);
    reg_read(2'd0, d); chk("R3 status 16", d, 32'h103);
    for (int i = 16; i < 32; i++) send_byte(8'(i * 7 + 3), 2'd2);
    reg_read(2'd0, d); chk("R3 status 32", d, 32'h207);
    for (int i = 32; i < 64; i++) send_byte(8'(i * 7 + 3), 2'd2);
    reg_read(2'd0, d); chk("R3 R9 status 64", d, 32'h40F);
    send_byte(8'hEE, 2'd2); send_byte(8'hDD, 2'd2);
    reg_read(2'd0, d); chk("R9 full drop count", d, 32'h40F);
    for (int w = 0; w < 16; w++) begin
      reg_read(2'd1, d); chk("R9 R4 drain word", d, model_pop());
    end
    reg_read(2'd0, d); chk("R9 drained", d, 32'h800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_lane();
    t_multi_lane();
    t_flush();
    t_underrun();
    t_fill();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule